// File: doc/BRIEF.md
# Port Command Reset and Dump Sequencer

This block sits behind the host command port of a network controller. The host hands it one 32-bit command word. The low nibble selects the operation and the upper bits carry a pointer into host memory. Two operations exist.

A selective reset sends a one-cycle idle request to the command unit and the receive unit. Nothing else is touched. Base registers, header data size, error counters, configuration and the address filters live outside this block and receive no strobe. A ready flag then stays low until a settle interval has elapsed in the system clock domain and also in the transmit clock domain. The transmit-side count runs in its own domain, and its completion crosses back through a two-flop synchronizer.

A dump copies internal state words, one per snapshot index, to a host-memory write port in rising address order starting at the pointer. It then writes a fixed completion signature. A dump leaves the units alone and does not drop ready, so it can be used to inspect a controller that has stopped responding.

Top module: `port_cmd_seq`

## Requirements
- R1: A command is accepted (`cmd_ack` high in the same cycle as `cmd_valid`) when `busy` is low and `cmd_word[3:0]` is 4'h2 (selective reset) or 4'h3 (dump). The dump base address is `{cmd_word[31:4], 4'h0}`.
- R2: A command with any other value in `cmd_word[3:0]` is not acknowledged and has no effect: no idle request, no write, `busy` stays low and `ready` stays high.
- R3: While `busy` is high, `cmd_ack` stays low and an offered command has no effect.
- R4: An accepted selective reset raises `cu_idle_req` and `ru_idle_req` together for exactly the one cycle after acceptance.
- R5: After an accepted selective reset, `ready` is low from the cycle after acceptance for at least 10 system clock cycles.
- R6: `ready` returns high only after at least 5 rising edges of `tx_clk` since acceptance, and within 40 system cycles when the transmit clock is near the system clock rate.
- R7: A dump writes words 0 to 148 in increasing order. Word i goes to base + 4*i with data `snap_data`, and `snap_idx` equals i while word i is offered.
- R8: The last write of a dump carries 32'h0000A006 at base + 596, for 150 writes in total.
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, valid, address and data hold steady into the next cycle.
- R10: `busy` is high from the cycle after acceptance until the cycle after the signature write is accepted (dump), or until `ready` returns (reset). It is low in that following cycle.
- R11: After the system reset, `busy`, `mem_wr_valid`, `cu_idle_req` and `ru_idle_req` are low and `ready` is high.
- R12: A dump raises no idle request, and `ready` stays high throughout it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, system domain |
| tx_clk | input | 1 | Transmit clock |
| tx_rst_n | input | 1 | Synchronous active-low reset, transmit domain |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 32 | Opcode in [3:0], pointer in [31:4] |
| cmd_ack | output | 1 | Command taken this cycle |
| cu_idle_req | output | 1 | One-cycle idle request to the command unit |
| ru_idle_req | output | 1 | One-cycle idle request to the receive unit |
| ready | output | 1 | Device accessible (settle interval complete) |
| busy | output | 1 | An operation is in progress |
| mem_wr_valid | output | 1 | Host-memory write offered |
| mem_wr_addr | output | 32 | Byte address of the write |
| mem_wr_data | output | 32 | Data word of the write |
| mem_wr_ready | input | 1 | Write accepted this cycle |
| snap_idx | output | 8 | Index of the requested snapshot word |
| snap_data | input | 32 | Snapshot word for `snap_idx`, same cycle |

## Verification
`cmd_ack` is combinational, so the bench samples it on the falling edge of the cycle in which the command is offered. The idle requests, `busy` and the first dump write come from registers loaded at the accepting edge, so they are checked on the falling edge one cycle later. For `ready` the bench counts low cycles on falling edges and counts transmit edges from acceptance to the rise, instead of predicting the exact cycle of the rise, because the domain crossing phase varies. It checks each write on the falling edge of the cycle in which it is accepted, and checks `busy` low on the next falling edge after the signature.

// File: rtl/port_cmd_pkg.sv
`timescale 1ns/1ps
// Package: shared opcode values, sequencer states and the dump signature.
// Assumes a 4-bit opcode field at the low end of the command word.
package port_cmd_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_SEL_RESET = 4'h2,
        OPC_DUMP      = 4'h3
    } port_opcode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DUMP   = 2'd2
    } seq_state_t;

    localparam logic [31:0] DUMP_SIGNATURE = 32'h0000_A006;

endpackage

// File: rtl/pcs_bit_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchronizer for a single level signal.
// Assumes the input changes at most once per several destination clocks
// (toggle handshake), so no pulse stretching is needed.
module pcs_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/pcs_cmd_decode.sv
`timescale 1ns/1ps
// Module: host command decode.
// Splits the command word into an opcode and a 16-byte aligned pointer.
// Accepts only known opcodes and only while the sequencer is idle.
// Purely combinational; the caller registers the results.
module pcs_cmd_decode
    import port_cmd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              busy,
    output logic              accept,
    output logic              take_reset,
    output logic              take_dump,
    output logic [WORD_W-1:0] dump_base
);

    logic [OPC_W-1:0] opcode;
    logic             is_reset;
    logic             is_dump;

    // Classify the opcode field.
    always_comb begin
        opcode   = cmd_word[OPC_W-1:0];
        is_reset = (opcode == OPC_SEL_RESET);
        is_dump  = (opcode == OPC_DUMP);
    end

    // Gate acceptance on idle state and a known opcode.
    always_comb begin
        take_reset = cmd_valid && !busy && is_reset;
        take_dump  = cmd_valid && !busy && is_dump;
        accept     = take_reset || take_dump;
    end

    assign dump_base = {cmd_word[WORD_W-1:OPC_W], {OPC_W{1'b0}}};

endmodule

// File: rtl/pcs_settle.sv
`timescale 1ns/1ps
// Module: two-domain settle timer.
// On start, counts SYS_SETTLE system clocks and, through a toggle handshake,
// TX_SETTLE transmit clocks. 'settled' is high once both have elapsed.
// Assumes start is not repeated before settled returns high.
module pcs_settle #(
    parameter int SYS_SETTLE  = 10,
    parameter int TX_SETTLE   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_clk,
    input  logic tx_rst_n,
    input  logic start,
    output logic settled
);

    localparam int SYS_CW = $clog2(SYS_SETTLE + 1);
    localparam int TX_CW  = $clog2(TX_SETTLE + 1);

    logic              req_tgl;
    logic [SYS_CW-1:0] sys_cnt;
    logic              req_seen;
    logic              tx_last;
    logic [TX_CW-1:0]  tx_cnt;
    logic              ack_tgl;
    logic              ack_seen;

    // System side: load the local count and toggle the request on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl <= 1'b0;
            sys_cnt <= '0;
        end else if (start) begin
            req_tgl <= ~req_tgl;
            sys_cnt <= SYS_CW'(SYS_SETTLE);
        end else if (sys_cnt != '0) begin
            sys_cnt <= sys_cnt - 1'b1;
        end
    end

    pcs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (tx_clk),
        .rst_n (tx_rst_n),
        .din   (req_tgl),
        .dout  (req_seen)
    );

    // Transmit side: on a new request, count and then echo the toggle.
    always_ff @(posedge tx_clk) begin
        if (!tx_rst_n) begin
            tx_last <= 1'b0;
            tx_cnt  <= '0;
            ack_tgl <= 1'b0;
        end else if (req_seen != tx_last) begin
            tx_last <= req_seen;
            tx_cnt  <= TX_CW'(TX_SETTLE);
        end else if (tx_cnt != '0) begin
            tx_cnt <= tx_cnt - 1'b1;
            if (tx_cnt == TX_CW'(1)) begin
                ack_tgl <= tx_last;
            end
        end
    end

    pcs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ack_tgl),
        .dout  (ack_seen)
    );

    assign settled = (sys_cnt == '0) && (ack_seen == req_tgl);

endmodule

// File: rtl/pcs_dump_seq.sv
`timescale 1ns/1ps
// Module: dump word sequencer.
// Streams DUMP_WORDS snapshot words to consecutive dword addresses from the
// base, then one signature word. A valid/ready write handshake holds each
// word until it is taken. Assumes snap_data answers snap_idx in the same cycle.
module pcs_dump_seq #(
    parameter int          WORD_W     = 32,
    parameter int          DUMP_WORDS = 149,
    parameter logic [31:0] SIGNATURE  = 32'h0000_A006,
    localparam int         IDX_W      = $clog2(DUMP_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] base,
    input  logic              wr_ready,
    input  logic [WORD_W-1:0] snap_data,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [IDX_W-1:0]  snap_idx,
    output logic              finished
);

    logic              active;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] off_q;
    logic              at_sig;

    // Advance the word index and byte offset on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
            off_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= base;
            off_q  <= '0;
        end else if (active && wr_ready) begin
            if (at_sig) begin
                active <= 1'b0;
            end else begin
                idx   <= idx + 1'b1;
                off_q <= off_q + WORD_W'(4);
            end
        end
    end

    // Form the write beat from the current index.
    always_comb begin
        at_sig   = (idx == IDX_W'(DUMP_WORDS));
        wr_valid = active;
        wr_addr  = base_q + off_q;
        wr_data  = at_sig ? WORD_W'(SIGNATURE) : snap_data;
        finished = active && wr_ready && at_sig;
    end

    assign snap_idx = idx;

endmodule

// File: rtl/port_cmd_seq.sv
`timescale 1ns/1ps
// Module: port command reset/dump sequencer (top).
// Decodes host port commands. A selective reset strobes the unit state
// machines to idle and holds ready low through a two-domain settle interval.
// A dump streams a state snapshot and a completion signature to host memory.
// Assumes both resets are applied together at power-up.
module port_cmd_seq
    import port_cmd_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYS_SETTLE  = 10,
    parameter int TX_SETTLE   = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DUMP_WORDS  = 149,
    localparam int IDX_W      = $clog2(DUMP_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              cmd_ack,
    output logic              cu_idle_req,
    output logic              ru_idle_req,
    output logic              ready,
    output logic              busy,
    output logic              mem_wr_valid,
    output logic [WORD_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready,
    output logic [IDX_W-1:0]  snap_idx,
    input  logic [WORD_W-1:0] snap_data
);

    seq_state_t        state;
    logic              idle_strobe;
    logic              take_reset;
    logic              take_dump;
    logic [WORD_W-1:0] dump_base;
    logic              settled;
    logic              dump_finished;

    pcs_cmd_decode #(.WORD_W(WORD_W)) u_decode (
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .busy       (busy),
        .accept     (cmd_ack),
        .take_reset (take_reset),
        .take_dump  (take_dump),
        .dump_base  (dump_base)
    );

    pcs_settle #(
        .SYS_SETTLE  (SYS_SETTLE),
        .TX_SETTLE   (TX_SETTLE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_clk   (tx_clk),
        .tx_rst_n (tx_rst_n),
        .start    (take_reset),
        .settled  (settled)
    );

    pcs_dump_seq #(
        .WORD_W     (WORD_W),
        .DUMP_WORDS (DUMP_WORDS),
        .SIGNATURE  (DUMP_SIGNATURE)
    ) u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take_dump),
        .base      (dump_base),
        .wr_ready  (mem_wr_ready),
        .snap_data (snap_data),
        .wr_valid  (mem_wr_valid),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .snap_idx  (snap_idx),
        .finished  (dump_finished)
    );

    // Sequence the accepted operation and emit the one-cycle idle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idle_strobe <= 1'b0;
        end else begin
            idle_strobe <= take_reset;
            unique case (state)
                ST_IDLE: begin
                    if (take_reset) begin
                        state <= ST_SETTLE;
                    end else if (take_dump) begin
                        state <= ST_DUMP;
                    end
                end
                ST_SETTLE: begin
                    if (settled) begin
                        state <= ST_IDLE;
                    end
                end
                ST_DUMP: begin
                    if (dump_finished) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the status and strobe outputs from the state.
    always_comb begin
        busy        = (state != ST_IDLE);
        ready       = (state != ST_SETTLE);
        cu_idle_req = idle_strobe;
        ru_idle_req = idle_strobe;
    end

endmodule

// File: rtl/port_cmd_seq_chk.sv
`timescale 1ns/1ps
// Module: property checker for port_cmd_seq, bound to every instance.
// Observes ports only; keeps one counter for the settle window length.
module port_cmd_seq_chk
    import port_cmd_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int SYS_SETTLE = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [WORD_W-1:0] cmd_word,
    input logic              cmd_ack,
    input logic              cu_idle_req,
    input logic              ru_idle_req,
    input logic              ready,
    input logic              busy,
    input logic              mem_wr_valid,
    input logic [WORD_W-1:0] mem_wr_addr,
    input logic [WORD_W-1:0] mem_wr_data,
    input logic              mem_wr_ready
);

    localparam int LC_W = $clog2(SYS_SETTLE + 2);
    localparam logic [LC_W-1:0] LC_MAX = {LC_W{1'b1}};

    logic [LC_W-1:0] low_cnt;

    // Count consecutive cycles with ready low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (ready) begin
            low_cnt <= '0;
        end else if (low_cnt != LC_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assert_unknown_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[OPC_W-1:0] != OPC_SEL_RESET
                   && cmd_word[OPC_W-1:0] != OPC_DUMP) |-> !cmd_ack);

    assert_busy_rejects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ack);

    assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cu_idle_req == ru_idle_req);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cu_idle_req |=> !cu_idle_req);

    assert_settle_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt >= LC_W'(SYS_SETTLE)));

    assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> busy);

    assert_dump_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (ready && busy && !cu_idle_req));

endmodule

bind port_cmd_seq port_cmd_seq_chk #(
    .WORD_W     (WORD_W),
    .SYS_SETTLE (SYS_SETTLE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .cmd_ack      (cmd_ack),
    .cu_idle_req  (cu_idle_req),
    .ru_idle_req  (ru_idle_req),
    .ready        (ready),
    .busy         (busy),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ready (mem_wr_ready)
);

// File: tb/port_cmd_seq_tb.sv
`timescale 1ns/1ps
// Bench for port_cmd_seq: directed corners plus seeded random commands,
// with a write monitor that predicts every dump beat.
module port_cmd_seq_tb;

    localparam int          SYS_SETTLE = 10;
    localparam int          TX_SETTLE  = 5;
    localparam int          DUMP_WORDS = 149;
    localparam logic [31:0] SIG        = 32'h0000_A006;

    logic        clk = 1'b0;
    logic        tx_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ack;
    logic        cu_idle_req;
    logic        ru_idle_req;
    logic        ready;
    logic        busy;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ready = 1'b0;
    logic [7:0]  snap_idx;
    logic [31:0] snap_data;

    always #10 clk = ~clk;
    always #17 tx_clk = ~tx_clk;

    function automatic logic [31:0] snap_val(input logic [7:0] i);
        return {i, 8'hC3, ~i, i ^ 8'h5A};
    endfunction

    assign snap_data = snap_val(snap_idx);

    port_cmd_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_clk       (tx_clk),
        .tx_rst_n     (tx_rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .cmd_ack      (cmd_ack),
        .cu_idle_req  (cu_idle_req),
        .ru_idle_req  (ru_idle_req),
        .ready        (ready),
        .busy         (busy),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready),
        .snap_idx     (snap_idx),
        .snap_data    (snap_data)
    );

    int checks = 0;
    int errors = 0;
    int ready_pct = 100;
    int tx_edges = 0;

    bit          dump_expect = 0;
    bit          dump_done = 0;
    bit          check_busy_low = 0;
    bit          prev_stall = 0;
    logic [31:0] dump_base = '0;
    logic [31:0] prev_addr = '0;
    logic [31:0] prev_data = '0;
    int          exp_idx = 0;
    int          strobe_cnt = 0;
    int          low_run = 0;
    int          last_low = 0;
    int          tx_at_rise = 0;
    bit          rise_seen = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge tx_clk) tx_edges++;

    // Drive the write-accept line with a random pattern.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            mem_wr_ready = (($urandom % 100) < ready_pct);
        end
    end

    // Monitor: strobes, ready windows and every dump beat.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cu_idle_req || ru_idle_req) begin
                strobe_cnt++;
                chk(cu_idle_req == ru_idle_req, "R4", {31'd0, ru_idle_req},
                    {31'd0, cu_idle_req}, "idle requests paired");
            end
            if (!ready) begin
                low_run++;
            end else begin
                if (low_run != 0) begin
                    last_low   = low_run;
                    tx_at_rise = tx_edges;
                    rise_seen  = 1;
                end
                low_run = 0;
            end
            if (check_busy_low) begin
                chk(!busy, "R10", {31'd0, busy}, 32'd0, "busy after signature");
                check_busy_low = 0;
            end
            if (mem_wr_valid) begin
                if (!dump_expect) begin
                    chk(0, "R7", mem_wr_addr, 32'd0, "write with no dump");
                end else begin
                    chk(ready, "R12", {31'd0, ready}, 32'd1, "ready during dump");
                    chk(busy, "R10", {31'd0, busy}, 32'd1, "busy during dump");
                    if (prev_stall) begin
                        chk(mem_wr_addr == prev_addr && mem_wr_data == prev_data,
                            "R9", mem_wr_addr, prev_addr, "beat held while stalled");
                    end
                    if (exp_idx < DUMP_WORDS) begin
                        chk(snap_idx == 8'(exp_idx), "R7", {24'd0, snap_idx},
                            32'(exp_idx), "snapshot index");
                    end
                    if (mem_wr_ready) begin
                        if (exp_idx < DUMP_WORDS) begin
                            chk(mem_wr_addr == dump_base + 32'(4 * exp_idx), "R7",
                                mem_wr_addr, dump_base + 32'(4 * exp_idx), "word address");
                            chk(mem_wr_data == snap_val(8'(exp_idx)), "R7",
                                mem_wr_data, snap_val(8'(exp_idx)), "word data");
                        end else begin
                            chk(mem_wr_addr == dump_base + 32'd596, "R8",
                                mem_wr_addr, dump_base + 32'd596, "signature address");
                            chk(mem_wr_data == SIG, "R8", mem_wr_data, SIG,
                                "signature data");
                        end
                        exp_idx++;
                        prev_stall = 0;
                        if (exp_idx == DUMP_WORDS + 1) begin
                            dump_expect    = 0;
                            dump_done      = 1;
                            check_busy_low = 1;
                        end
                    end else begin
                        prev_stall = 1;
                        prev_addr  = mem_wr_addr;
                        prev_data  = mem_wr_data;
                    end
                end
            end
        end
    end

    // Offer one command for one cycle; report whether it was taken.
    task automatic issue(input logic [31:0] w, output bit acked);
        @(posedge clk);
        #2;
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        acked = cmd_ack;
        if (acked && w[3:0] == 4'h3) begin
            dump_base   = {w[31:4], 4'h0};
            exp_idx     = 0;
            prev_stall  = 0;
            dump_done   = 0;
            dump_expect = 1;
        end
        @(posedge clk);
        #2;
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset_cmd(input logic [31:0] w);
        bit acked;
        bit rej;
        int s0;
        int tx0;
        int n;
        s0 = strobe_cnt;
        rise_seen = 0;
        tx0 = tx_edges;
        issue(w, acked);
        chk(acked, "R1", {31'd0, acked}, 32'd1, "reset accepted");
        @(negedge clk);
        chk(cu_idle_req && ru_idle_req, "R4", {30'd0, cu_idle_req, ru_idle_req},
            32'd3, "idle strobe after accept");
        chk(!ready, "R5", {31'd0, ready}, 32'd0, "ready low after reset");
        chk(busy, "R10", {31'd0, busy}, 32'd1, "busy during settle");
        @(negedge clk);
        chk(!cu_idle_req, "R4", {31'd0, cu_idle_req}, 32'd0, "strobe width");
        issue({w[31:4], 4'h3}, rej);
        chk(!rej, "R3", {31'd0, rej}, 32'd0, "dump rejected while settling");
        n = 0;
        while (!rise_seen && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(rise_seen, "R6", {31'd0, rise_seen}, 32'd1, "ready returns in bound");
        chk(last_low >= SYS_SETTLE, "R5", 32'(last_low), 32'(SYS_SETTLE),
            "ready low cycles");
        chk(tx_at_rise - tx0 >= TX_SETTLE, "R6", 32'(tx_at_rise - tx0),
            32'(TX_SETTLE), "tx edges before ready");
        @(negedge clk);
        chk(!busy, "R10", {31'd0, busy}, 32'd0, "busy clear after settle");
        chk(strobe_cnt == s0 + 1, "R4", 32'(strobe_cnt), 32'(s0 + 1), "one strobe");
    endtask

    task automatic do_dump(input logic [31:0] w);
        bit acked;
        bit rej;
        int s0;
        int n;
        s0 = strobe_cnt;
        issue(w, acked);
        chk(acked, "R1", {31'd0, acked}, 32'd1, "dump accepted");
        issue({w[31:4], 4'h2}, rej);
        chk(!rej, "R3", {31'd0, rej}, 32'd0, "reset rejected while dumping");
        n = 0;
        while (!dump_done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(exp_idx == DUMP_WORDS + 1, "R8", 32'(exp_idx), 32'(DUMP_WORDS + 1),
            "write count");
        chk(strobe_cnt == s0, "R12", 32'(strobe_cnt), 32'(s0), "no strobe in dump");
        chk(!busy && ready, "R10", {30'd0, busy, ready}, 32'd1, "idle after dump");
    endtask

    task automatic do_unknown(input logic [31:0] w);
        bit acked;
        int s0;
        s0 = strobe_cnt;
        issue(w, acked);
        chk(!acked, "R2", {31'd0, acked}, 32'd0, "unknown opcode not taken");
        repeat (4) @(negedge clk);
        chk(!busy && ready && strobe_cnt == s0, "R2", {30'd0, busy, ready},
            32'd1, "unknown opcode no effect");
    endtask

    // Main sequence.
    initial begin
        logic [31:0] w;
        void'($urandom(32'd7341));
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tx_rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R11", {31'd0, busy}, 32'd0, "busy after reset");
        chk(ready, "R11", {31'd0, ready}, 32'd1, "ready after reset");
        chk(!mem_wr_valid, "R11", {31'd0, mem_wr_valid}, 32'd0, "no write after reset");
        chk(!cu_idle_req && !ru_idle_req, "R11", {30'd0, cu_idle_req, ru_idle_req},
            32'd0, "no strobe after reset");

        do_unknown(32'h1234_5670);
        do_unknown(32'hFFFF_FFFF);
        do_unknown(32'h0000_0001);
        do_reset_cmd(32'h0000_0002);
        ready_pct = 100;
        do_dump(32'h0000_0003);
        ready_pct = 40;
        do_dump(32'hFFFF_FF03);
        ready_pct = 70;
        do_reset_cmd(32'hABCD_EF02);

        for (int k = 0; k < 12; k++) begin
            w = $urandom;
            if (k % 3 == 0) w[3:0] = 4'h3;
            else if (k % 3 == 1) w[3:0] = 4'h2;
            ready_pct = 30 + ($urandom % 71);
            if (w[3:0] == 4'h2) do_reset_cmd(w);
            else if (w[3:0] == 4'h3) do_dump(w);
            else do_unknown(w);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule